// File: doc/BRIEF.md
# Address-Wakeup UART Receiver

This block receives asynchronous serial frames on a single line, sampled against a 16x oversampling tick from an external rate generator. In address mode each frame carries one extra bit after the data byte. This bit marks the byte as a node address (1) or as ordinary data (0), so several receivers can share one line and only the addressed node takes the data that follows.

Software arms a wake latch. While it is armed and address mode is on, every frame whose extra bit is 0 is discarded without touching any flag. The first frame whose extra bit is 1 is delivered in the normal way, and the same event disarms the latch. The receive byte register, the data-ready, framing-error and overrun flags, and two level interrupt lines (data and error) behave as in a plain receiver whenever the filter is not blocking a frame.

Top module: `awu_uart_rx`

## Requirements
- R1: After reset, `full_o`, `ferr_o`, `ovr_o`, `abit_o`, `wake_o`, `rx_irq_o` and `err_irq_o` are all 0.
- R2: A frame is a low start bit, 8 data bits with the least significant bit first, then (only when `addr_mode_i` is 1) the address bit, then a stop bit. Each bit lasts 16 ticks. The start bit is checked on the 8th tick after it is first seen low, and each following bit is sampled 16 ticks after the previous sample.
- R3: A low pulse that has returned high by the start-bit check produces no frame and changes no output.
- R4: An accepted frame loads `rx_data_o` and sets `full_o`, two clocks after the tick that samples the stop bit. With `addr_mode_i` at 0 the wake latch has no effect, and `abit_o` takes 0.
- R5: With `wake_o`=1, `addr_mode_i`=1 and `sync_mode_i`=0, a frame whose address bit is 0 leaves `rx_data_o`, `full_o`, `ferr_o`, `ovr_o`, `abit_o`, `wake_o` and both interrupt lines unchanged, even when its stop bit is low.
- R6: Under the conditions of R5, a frame whose address bit is 1 is delivered, sets `abit_o` to 1 and clears `wake_o`.
- R7: With `sync_mode_i`=1 the wake latch is ignored: frames with address bit 0 are delivered, and `wake_o` stays as written.
- R8: A stop bit sampled low on an accepted frame sets `ferr_o`. The byte is still delivered, and the receiver then waits for the line to go high before it looks for the next start bit.
- R9: A frame accepted while `full_o` is 1 sets `ovr_o` and leaves `rx_data_o` at its old value.
- R10: `rx_irq_o` is `irq_en_i` AND `full_o`; `err_irq_o` is `irq_en_i` AND (`ferr_o` OR `ovr_o`).
- R11: A one-clock pulse on `wake_we_i` loads `wake_wd_i` into the wake latch. Such a write wins over the automatic disarm in the same clock, and writing 0 ends filtering from the next frame on.
- R12: Pulses on `clr_full_i`, `clr_ferr_i` and `clr_ovr_i` clear their flags. A flag set by a frame in the same clock stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | One-clock pulse at 16 times the bit rate |
| addr_mode_i | input | 1 | Frames carry an address bit |
| sync_mode_i | input | 1 | Synchronous mode selected; disables the wake filter |
| irq_en_i | input | 1 | Enable for both interrupt lines |
| wake_we_i | input | 1 | Write strobe for the wake latch |
| wake_wd_i | input | 1 | Value written to the wake latch |
| clr_full_i | input | 1 | Clear the data-ready flag |
| clr_ferr_i | input | 1 | Clear the framing-error flag |
| clr_ovr_i | input | 1 | Clear the overrun flag |
| rx_data_o | output | 8 | Received byte register |
| full_o | output | 1 | Data-ready flag |
| ferr_o | output | 1 | Framing-error flag |
| ovr_o | output | 1 | Overrun flag |
| abit_o | output | 1 | Address bit of the last delivered frame |
| wake_o | output | 1 | Wake latch state |
| rx_irq_o | output | 1 | Receive-data interrupt |
| err_irq_o | output | 1 | Receive-error interrupt |

## Verification
The properties assume that `tick_i` is a single-clock pulse with idle clocks between pulses, that the mode inputs stay constant for the length of a frame, and that a frame needs far more clocks than the two-stage delivery path. Under these assumptions a frame-done pulse never repeats on consecutive clocks, and the filter decision never sees a mode change partway through a frame. The stimulus pulses the tick once every four clocks and changes `rxd_i` only between ticks. Mode, enable and clear inputs change only while the line is idle, except for the deliberate same-clock clashes that R11 and R12 call for.

// File: rtl/awu_rx_pkg.sv
package awu_rx_pkg;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_SHIFT,
    FR_STOP,
    FR_HOLD
  } fr_state_e;

  // filter is live only for asynchronous address mode with the latch set
  function automatic logic wake_armed(input logic latch, input logic amode, input logic smode);
    return latch & amode & ~smode;
  endfunction

  // a frame passes unless the filter is live and it is not an address
  function automatic logic frame_passes(input logic armed, input logic abit);
    return ~armed | abit;
  endfunction

  function automatic logic err_level(input logic ferr, input logic ovr);
    return ferr | ovr;
  endfunction

endpackage

// File: rtl/awu_rx_framer.sv
module awu_rx_framer
  import awu_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_i,
  input  logic              tick_i,
  input  logic              amode_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              abit_o,
  output logic              stop_ok_o
);

  localparam int PH_W = $clog2(OVS);
  localparam int IX_W = $clog2(DATA_W + 1);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS / 2 - 2);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

  fr_state_e         state_q;
  logic [PH_W-1:0]   ph_q;
  logic [IX_W-1:0]   ix_q;
  logic [IX_W-1:0]   last_ix;
  logic [DATA_W:0]   shreg_q;
  logic              amode_q;
  logic              done_q;
  logic              stop_q;

  assign last_ix = IX_W'(DATA_W - 1) + {{(IX_W-1){1'b0}}, amode_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      ph_q    <= '0;
      ix_q    <= '0;
      shreg_q <= '0;
      amode_q <= 1'b0;
      done_q  <= 1'b0;
      stop_q  <= 1'b1;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        FR_IDLE: begin
          if (tick_i && !rxd_i) begin
            state_q <= FR_START;
            ph_q    <= '0;
            amode_q <= amode_i;
          end
        end
        FR_START: begin
          if (tick_i) begin
            if (ph_q == PH_MID) begin
              ph_q <= '0;
              if (!rxd_i) begin
                state_q <= FR_SHIFT;
                shreg_q <= '0;
                ix_q    <= '0;
              end else begin
                state_q <= FR_IDLE;
              end
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
        end
        FR_SHIFT: begin
          if (tick_i) begin
            if (ph_q == PH_LAST) begin
              ph_q          <= '0;
              shreg_q[ix_q] <= rxd_i;
              if (ix_q == last_ix) state_q <= FR_STOP;
              else                 ix_q    <= ix_q + 1'b1;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
        end
        FR_STOP: begin
          if (tick_i) begin
            if (ph_q == PH_LAST) begin
              ph_q    <= '0;
              done_q  <= 1'b1;
              stop_q  <= rxd_i;
              state_q <= rxd_i ? FR_IDLE : FR_HOLD;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
        end
        FR_HOLD: begin
          if (rxd_i) state_q <= FR_IDLE;
        end
        default: state_q <= FR_IDLE;
      endcase
    end
  end

  assign done_o    = done_q;
  assign data_o    = shreg_q[DATA_W-1:0];
  assign abit_o    = shreg_q[DATA_W];
  assign stop_ok_o = stop_q;

endmodule

// File: rtl/awu_rx_wake.sv
module awu_rx_wake
  import awu_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we_i,
  input  logic wd_i,
  input  logic amode_i,
  input  logic smode_i,
  input  logic done_i,
  input  logic abit_i,
  output logic wake_o,
  output logic pass_o,
  output logic hit_o
);

  logic latch_q;
  logic armed;

  assign armed  = wake_armed(latch_q, amode_i, smode_i);
  assign pass_o = done_i & frame_passes(armed, abit_i);
  assign hit_o  = done_i & armed & abit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     latch_q <= 1'b0;
    else if (we_i)  latch_q <= wd_i;
    else if (hit_o) latch_q <= 1'b0;
  end

  assign wake_o = latch_q;

endmodule

// File: rtl/awu_rx_flags.sv
module awu_rx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pass_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              abit_i,
  input  logic              stop_ok_i,
  input  logic              clr_full_i,
  input  logic              clr_ferr_i,
  input  logic              clr_ovr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              ferr_o,
  output logic              ovr_o,
  output logic              abit_o
);

  logic [DATA_W-1:0] data_q, data_n;
  logic full_q, full_n, ferr_q, ferr_n, ovr_q, ovr_n, abit_q, abit_n;

  always_comb begin
    data_n = data_q;
    abit_n = abit_q;
    full_n = full_q & ~clr_full_i;
    ferr_n = ferr_q & ~clr_ferr_i;
    ovr_n  = ovr_q  & ~clr_ovr_i;
    if (pass_i) begin
      abit_n = abit_i;
      if (full_q) begin
        ovr_n = 1'b1;
      end else begin
        full_n = 1'b1;
        data_n = data_i;
      end
      if (!stop_ok_i) ferr_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
      abit_q <= 1'b0;
    end else begin
      data_q <= data_n;
      full_q <= full_n;
      ferr_q <= ferr_n;
      ovr_q  <= ovr_n;
      abit_q <= abit_n;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign ferr_o = ferr_q;
  assign ovr_o  = ovr_q;
  assign abit_o = abit_q;

endmodule

// File: rtl/awu_uart_rx.sv
module awu_uart_rx
  import awu_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_i,
  input  logic              tick_i,
  input  logic              addr_mode_i,
  input  logic              sync_mode_i,
  input  logic              irq_en_i,
  input  logic              wake_we_i,
  input  logic              wake_wd_i,
  input  logic              clr_full_i,
  input  logic              clr_ferr_i,
  input  logic              clr_ovr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              full_o,
  output logic              ferr_o,
  output logic              ovr_o,
  output logic              abit_o,
  output logic              wake_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);

  // internal events, named for the checker
  logic              fr_done;
  logic [DATA_W-1:0] fr_data;
  logic              fr_abit;
  logic              fr_stop_ok;
  logic              fr_pass;
  logic              wake_hit;

  awu_rx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxd_i     (rxd_i),
    .tick_i    (tick_i),
    .amode_i   (addr_mode_i),
    .done_o    (fr_done),
    .data_o    (fr_data),
    .abit_o    (fr_abit),
    .stop_ok_o (fr_stop_ok)
  );

  awu_rx_wake u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (wake_we_i),
    .wd_i    (wake_wd_i),
    .amode_i (addr_mode_i),
    .smode_i (sync_mode_i),
    .done_i  (fr_done),
    .abit_i  (fr_abit),
    .wake_o  (wake_o),
    .pass_o  (fr_pass),
    .hit_o   (wake_hit)
  );

  awu_rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .pass_i     (fr_pass),
    .data_i     (fr_data),
    .abit_i     (fr_abit),
    .stop_ok_i  (fr_stop_ok),
    .clr_full_i (clr_full_i),
    .clr_ferr_i (clr_ferr_i),
    .clr_ovr_i  (clr_ovr_i),
    .data_o     (rx_data_o),
    .full_o     (full_o),
    .ferr_o     (ferr_o),
    .ovr_o      (ovr_o),
    .abit_o     (abit_o)
  );

  assign rx_irq_o  = irq_en_i & full_o;
  assign err_irq_o = irq_en_i & err_level(ferr_o, ovr_o);

endmodule

// File: rtl/awu_uart_rx_chk.sv
module awu_uart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_mode_i,
  input logic              sync_mode_i,
  input logic              irq_en_i,
  input logic              wake_we_i,
  input logic              wake_wd_i,
  input logic              clr_full_i,
  input logic              clr_ferr_i,
  input logic              clr_ovr_i,
  input logic              fr_done,
  input logic              fr_abit,
  input logic              fr_stop_ok,
  input logic              fr_pass,
  input logic              wake_o,
  input logic              full_o,
  input logic              ferr_o,
  input logic              ovr_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_irq_o,
  input logic              err_irq_o
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done |=> !fr_done); // R2

  AST_LATCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && (!addr_mode_i || sync_mode_i)) |-> fr_pass); // R4

  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && wake_o && addr_mode_i && !sync_mode_i && !fr_abit &&
     !clr_full_i && !clr_ferr_i && !clr_ovr_i)
    |=> ($stable(full_o) && $stable(ferr_o) && $stable(ovr_o) && $stable(rx_data_o))); // R5

  AST_AUTO_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && wake_o && addr_mode_i && !sync_mode_i && fr_abit && !wake_we_i)
    |=> !wake_o); // R6

  AST_FERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_pass && !fr_stop_ok) |=> ferr_o); // R8

  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_pass && full_o && !clr_full_i) |=> (ovr_o && $stable(rx_data_o))); // R9

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> (!rx_irq_o && !err_irq_o)); // R10

  AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_we_i |=> (wake_o == $past(wake_wd_i))); // R11

endmodule

bind awu_uart_rx awu_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_mode_i (addr_mode_i),
  .sync_mode_i (sync_mode_i),
  .irq_en_i    (irq_en_i),
  .wake_we_i   (wake_we_i),
  .wake_wd_i   (wake_wd_i),
  .clr_full_i  (clr_full_i),
  .clr_ferr_i  (clr_ferr_i),
  .clr_ovr_i   (clr_ovr_i),
  .fr_done     (fr_done),
  .fr_abit     (fr_abit),
  .fr_stop_ok  (fr_stop_ok),
  .fr_pass     (fr_pass),
  .wake_o      (wake_o),
  .full_o      (full_o),
  .ferr_o      (ferr_o),
  .ovr_o       (ovr_o),
  .rx_data_o   (rx_data_o),
  .rx_irq_o    (rx_irq_o),
  .err_irq_o   (err_irq_o)
);

// File: tb/awu_uart_rx_tb_top.sv
module awu_uart_rx_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic rxd = 1'b1, tick = 1'b0;
  logic addr_mode = 1'b0, sync_mode = 1'b0, irq_en = 1'b0;
  logic wake_we = 1'b0, wake_wd = 1'b0;
  logic clr_full = 1'b0, clr_ferr = 1'b0, clr_ovr = 1'b0;

  logic [7:0] rx_data;
  logic full, ferr, ovr, abit, wake, rx_irq, err_irq;

  awu_uart_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .tick_i(tick),
    .addr_mode_i(addr_mode), .sync_mode_i(sync_mode), .irq_en_i(irq_en),
    .wake_we_i(wake_we), .wake_wd_i(wake_wd),
    .clr_full_i(clr_full), .clr_ferr_i(clr_ferr), .clr_ovr_i(clr_ovr),
    .rx_data_o(rx_data), .full_o(full), .ferr_o(ferr), .ovr_o(ovr),
    .abit_o(abit), .wake_o(wake), .rx_irq_o(rx_irq), .err_irq_o(err_irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit fin = 0;

  // behavioural reference model
  logic [7:0] m_data = '0;
  logic m_full = 0, m_ferr = 0, m_ovr = 0, m_abit = 0, m_wake = 0;
  logic m_filter, m_take, m_hit, m_was_full;
  bit   ev0_v = 0, ev1_v = 0;
  logic [7:0] ev0_d, ev1_d;
  logic ev0_a, ev1_a, ev0_s, ev1_s;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data = '0; m_full = 0; m_ferr = 0; m_ovr = 0; m_abit = 0; m_wake = 0;
      ev0_v = 0; ev1_v = 0;
    end else begin
      m_filter   = m_wake && addr_mode && !sync_mode;
      m_take     = ev1_v && (!m_filter || ev1_a);
      m_hit      = ev1_v && m_filter && ev1_a;
      m_was_full = m_full;
      if (clr_full) m_full = 0;
      if (clr_ferr) m_ferr = 0;
      if (clr_ovr)  m_ovr  = 0;
      if (m_take) begin
        m_abit = ev1_a;
        if (m_was_full) m_ovr = 1;
        else begin m_full = 1; m_data = ev1_d; end
        if (!ev1_s) m_ferr = 1;
      end
      if (wake_we)    m_wake = wake_wd;
      else if (m_hit) m_wake = 0;
      ev1_v = ev0_v; ev1_d = ev0_d; ev1_a = ev0_a; ev1_s = ev0_s;
      ev0_v = 0;
    end
  end

  task automatic fld(input string tag, input string nm, input logic [7:0] act,
                     input logic [7:0] exp, inout bit bad);
    if (act !== exp) begin
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
      bad = 1;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      bit bad;
      bad = 0;
      fld("R4", "rx_data", rx_data, m_data, bad);
      fld("R4", "full", {7'd0, full}, {7'd0, m_full}, bad);
      fld("R8", "ferr", {7'd0, ferr}, {7'd0, m_ferr}, bad);
      fld("R9", "ovr", {7'd0, ovr}, {7'd0, m_ovr}, bad);
      fld("R6", "abit", {7'd0, abit}, {7'd0, m_abit}, bad);
      fld("R11", "wake", {7'd0, wake}, {7'd0, m_wake}, bad);
      fld("R10", "rx_irq", {7'd0, rx_irq}, {7'd0, irq_en & m_full}, bad);
      fld("R10", "err_irq", {7'd0, err_irq}, {7'd0, irq_en & (m_ferr | m_ovr)}, bad);
      n_cmp++;
      if (bad) n_bad++;
    end
  end

  task automatic chk(input string tag, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic ab, input logic stopv,
                      input bit race_we = 0, input logic race_wd = 0,
                      input bit race_cf = 0);
    logic [10:0] vec;
    int nb;
    vec = '1;
    vec[0] = 1'b0;
    for (int i = 0; i < 8; i++) vec[1+i] = d[i];
    if (addr_mode) begin vec[9] = ab; vec[10] = stopv; nb = 11; end
    else begin vec[9] = stopv; nb = 10; end
    for (int b = 0; b < nb; b++) begin
      rxd = vec[b];
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        tick = 1;
        if (b == nb - 1 && k == 7) begin
          ev0_v = 1; ev0_d = d; ev0_a = addr_mode ? ab : 1'b0; ev0_s = stopv;
        end
        @(negedge clk);
        tick = 0;
        if (b == nb - 1 && k == 7) begin
          if (race_we) begin wake_we = 1; wake_wd = race_wd; end
          if (race_cf) clr_ferr = 1;
        end
        @(negedge clk);
        wake_we = 0; clr_ferr = 0;
        @(negedge clk);
      end
    end
    rxd = 1;
    idle(4);
  endtask

  task automatic wr_wake(input logic v);
    @(negedge clk) begin wake_we = 1; wake_wd = v; end
    @(negedge clk) wake_we = 0;
  endtask

  task automatic clr_all();
    @(negedge clk) begin clr_full = 1; clr_ferr = 1; clr_ovr = 1; end
    @(negedge clk) begin clr_full = 0; clr_ferr = 0; clr_ovr = 0; end
  endtask

  task automatic finish_run();
    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "full", {7'd0, full}, 8'd0);
    chk("R1", "ferr|ovr", {6'd0, ferr, ovr}, 8'd0);
    chk("R1", "wake|abit", {6'd0, wake, abit}, 8'd0);
    chk("R1", "irqs", {6'd0, rx_irq, err_irq}, 8'd0);
    irq_en = 1;
    idle(2);

    // R2 R4 plain frame, LSB first
    send(8'hA5, 0, 1);
    chk("R2", "byte order", rx_data, 8'hA5);
    chk("R4", "full", {7'd0, full}, 8'd1);
    chk("R10", "rx_irq", {7'd0, rx_irq}, 8'd1);
    clr_all();

    // R9 overrun keeps old byte
    send(8'h3C, 0, 1);
    send(8'hC3, 0, 1);
    chk("R9", "ovr", {7'd0, ovr}, 8'd1);
    chk("R9", "kept byte", rx_data, 8'h3C);
    chk("R10", "err_irq", {7'd0, err_irq}, 8'd1);
    clr_all();
    chk("R12", "flags cleared", {5'd0, full, ferr, ovr}, 8'd0);

    // R3 short low pulse
    rxd = 0; idle(4); rxd = 1; idle(24);
    chk("R3", "no frame", {7'd0, full}, 8'd0);
    chk("R3", "byte unchanged", rx_data, 8'h3C);

    // R8 framing error, then recovery
    send(8'h5A, 0, 0);
    chk("R8", "ferr", {7'd0, ferr}, 8'd1);
    chk("R8", "byte", rx_data, 8'h5A);
    clr_all();
    send(8'h96, 0, 1);
    chk("R8", "next frame after hold", rx_data, 8'h96);
    chk("R8", "ferr stays clear", {7'd0, ferr}, 8'd0);
    clr_all();

    // R5 R6 address filtering
    addr_mode = 1;
    wr_wake(1);
    send(8'h11, 0, 1);
    chk("R5", "dropped full", {7'd0, full}, 8'd0);
    chk("R5", "dropped byte", rx_data, 8'h96);
    chk("R5", "still armed", {7'd0, wake}, 8'd1);
    send(8'h22, 0, 0);
    chk("R5", "no ferr on drop", {6'd0, ferr, rx_irq}, 8'd0);
    send(8'h42, 1, 1);
    chk("R6", "address byte", rx_data, 8'h42);
    chk("R6", "abit", {7'd0, abit}, 8'd1);
    chk("R6", "disarmed", {7'd0, wake}, 8'd0);
    clr_all();
    send(8'h55, 0, 1);
    chk("R4", "data after wake", rx_data, 8'h55);
    chk("R4", "abit zero", {7'd0, abit}, 8'd0);
    clr_all();

    // R7 synchronous mode bypasses filter
    wr_wake(1);
    sync_mode = 1;
    send(8'h77, 0, 1);
    chk("R7", "delivered", rx_data, 8'h77);
    chk("R7", "latch kept", {7'd0, wake}, 8'd1);
    sync_mode = 0;
    clr_all();

    // R4 address mode off ignores latch
    addr_mode = 0;
    send(8'h81, 0, 1);
    chk("R4", "latch ignored", rx_data, 8'h81);
    chk("R4", "latch kept", {7'd0, wake}, 8'd1);
    clr_all();

    // R11 write wins over auto disarm; write 0 ends filter
    addr_mode = 1;
    send(8'h24, 1, 1, 1, 1);
    chk("R11", "write beats disarm", {7'd0, wake}, 8'd1);
    chk("R11", "address delivered", rx_data, 8'h24);
    clr_all();
    wr_wake(0);
    send(8'h66, 0, 1);
    chk("R11", "filter ended", rx_data, 8'h66);
    clr_all();

    // R12 set beats clear in the same clock
    send(8'h99, 1, 0, 0, 0, 1);
    chk("R12", "ferr kept", {7'd0, ferr}, 8'd1);
    clr_all();

    // R10 enable low masks both lines
    irq_en = 0;
    send(8'h01, 0, 0);
    chk("R10", "masked", {6'd0, rx_irq, err_irq}, 8'd0);
    chk("R10", "flags set", {6'd0, full, ferr}, 8'd3);
    clr_all();
    idle(2);
    finish_run();
  end

endmodule